// File: doc/BRIEF.md
# Data Access Debug Checker

This block sits beside a core's load/store path and inspects each data access as it is issued. It applies process-ID relocation to the address, checks word alignment when that check is enabled, and matches the relocated address against two data-breakpoint comparators. The results appear as registered outputs one cycle after the access. They are the relocated address, an alignment-abort pulse with the fault status and fault address to capture, a breakpoint-hit pulse, and an updated debug control/status word that carries a new entry-reason code.

The comparators work in one of two modes. In dual mode each comparator holds its own word address. In mask mode comparator 0 is compared under a mask, and the second address register supplies that mask with its bits inverted. Each comparator has a two-bit enable that selects loads only, stores only, any access, or off.

When bit 31 of the debug control/status word is set, a debug handler already owns the core. A match then raises no breakpoint trap. Instead the block records the entry reason by writing the data-breakpoint code into bits 4:2 of the status word.

Top module: `mem_access_dbg_chk`

## Requirements
- R1: After reset, every output is zero.
- R2: When `pid_field` is nonzero and address bits 31:25 are all zero, `mapped_addr` equals the address with `pid_field` ORed into bits 31:25. All later checks use this relocated address.
- R3: When `pid_field` is zero, or any of address bits 31:25 is set, `mapped_addr` equals the input address unchanged.
- R4: When `align_en` is 1 and mapped address bits 1:0 are nonzero, `align_abort` pulses. In the same cycle `fault_status` becomes `FAULT_CODE` (default 32'h1) and `fault_addr` becomes the mapped address. Both values hold until the next abort.
- R5: When `align_en` is 0, a misaligned access raises no abort.
- R6: Each comparator enable field uses this encoding: 0 is off, 1 matches stores only, 2 matches any access, 3 matches loads only. `bp_en0` controls comparator 0 and `bp_en1` controls comparator 1.
- R7: When `bp_mask_mode` is 1, comparator 0 matches if the mapped address equals `bp_addr0` on every bit that is zero in `bp_addr1`. In this mode comparator 1 never matches.
- R8: When `bp_mask_mode` is 0, a comparator matches if mapped address bits 31:2 equal bits 31:2 of its own address register. A match on either comparator counts.
- R9: When bit 31 of `dbg_csr` is 0, a match pulses `bp_hit`. When bit 31 is 1, a match gives no `bp_hit`. Instead it pulses `moe_wr` with `dbg_csr_upd` equal to `dbg_csr` with bits 4:2 replaced by `MOE_DBKPT` (default 3'b010). `dbg_csr_upd` holds between updates.
- R10: `align_abort`, `bp_hit` and `moe_wr` are single-cycle pulses. They appear only in the cycle after an access with `acc_valid` high, and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| pid_field | input | 7 | Process-ID relocation field |
| align_en | input | 1 | Alignment-check enable from the control register |
| dbg_csr | input | 32 | Debug control/status register value |
| bp_addr0 | input | 32 | Breakpoint address register 0 |
| bp_addr1 | input | 32 | Breakpoint address register 1, or the inverse mask in mask mode |
| bp_en0 | input | 2 | Comparator 0 enable field |
| bp_en1 | input | 2 | Comparator 1 enable field |
| bp_mask_mode | input | 1 | Selects mask mode |
| mapped_addr | output | 32 | Relocated address of the last access |
| align_abort | output | 1 | Alignment data-abort pulse |
| fault_status | output | 32 | Fault status value to capture |
| fault_addr | output | 32 | Fault address value to capture |
| bp_hit | output | 1 | Data-breakpoint trap pulse |
| moe_wr | output | 1 | Entry-reason update pulse |
| dbg_csr_upd | output | 32 | Updated debug control/status value |

## Verification
The assertions assume that the configuration inputs stay stable during an access, and that `acc_valid` is a clean level sampled once per cycle. The bench changes its inputs only on falling edges and follows every access with an idle cycle, so each pulse can be seen to rise and fall. Random addresses are often derived from the breakpoint registers, and their high bits are often cleared. This keeps matches and relocation frequent rather than rare.

// File: rtl/mem_access_dbg_chk.sv
module mem_access_dbg_chk #(
  parameter int AW = 32,
  parameter int PIDW = 7,
  parameter logic [31:0] FAULT_CODE = 32'h1,
  parameter logic [2:0] MOE_DBKPT = 3'b010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_store,
  input  logic [PIDW-1:0] pid_field,
  input  logic          align_en,
  input  logic [31:0]   dbg_csr,
  input  logic [AW-1:0] bp_addr0,
  input  logic [AW-1:0] bp_addr1,
  input  logic [1:0]    bp_en0,
  input  logic [1:0]    bp_en1,
  input  logic          bp_mask_mode,
  output logic [AW-1:0] mapped_addr,
  output logic          align_abort,
  output logic [31:0]   fault_status,
  output logic [AW-1:0] fault_addr,
  output logic          bp_hit,
  output logic          moe_wr,
  output logic [31:0]   dbg_csr_upd
);
  localparam int LOW = AW - PIDW;

  logic [AW-1:0] maddr;
  logic          misal, en0_ok, en1_ok, hit0, hit1, match, owned;

  function automatic logic kind_ok(input logic [1:0] en, input logic st);
    return (en == 2'd2) || (en == 2'd1 && st) || (en == 2'd3 && !st);
  endfunction

  assign maddr = (pid_field != '0 && acc_addr[AW-1:LOW] == '0)
               ? (acc_addr | {pid_field, {LOW{1'b0}}}) : acc_addr;
  assign misal  = align_en && (maddr[1:0] != 2'b00);
  assign en0_ok = kind_ok(bp_en0, acc_store);
  assign en1_ok = kind_ok(bp_en1, acc_store);
  assign hit0 = en0_ok && (bp_mask_mode
              ? (((maddr ^ bp_addr0) & ~bp_addr1) == '0)
              : (maddr[AW-1:2] == bp_addr0[AW-1:2]));
  assign hit1 = !bp_mask_mode && en1_ok && (maddr[AW-1:2] == bp_addr1[AW-1:2]);
  assign match = acc_valid && (hit0 || hit1);
  assign owned = dbg_csr[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapped_addr  <= '0;
      align_abort  <= 1'b0;
      fault_status <= '0;
      fault_addr   <= '0;
      bp_hit       <= 1'b0;
      moe_wr       <= 1'b0;
      dbg_csr_upd  <= '0;
    end else begin
      align_abort <= acc_valid && misal;
      bp_hit      <= match && !owned;
      moe_wr      <= match && owned;
      if (acc_valid) mapped_addr <= maddr;
      if (acc_valid && misal) begin
        fault_status <= FAULT_CODE;
        fault_addr   <= maddr;
      end
      if (match && owned) dbg_csr_upd <= {dbg_csr[31:5], MOE_DBKPT, dbg_csr[1:0]};
    end
  end

  a_r10_abort_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    align_abort |-> $past(acc_valid));
  a_r10_hit_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_hit || moe_wr) |-> $past(acc_valid));
  a_r9_hit_excludes_moe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_hit && moe_wr));
  a_r9_moe_field: assert property (@(posedge clk) disable iff (!rst_n)
    moe_wr |-> (dbg_csr_upd[4:2] == MOE_DBKPT && dbg_csr_upd[31]));
  a_r4_far_is_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    align_abort |-> (fault_addr == mapped_addr && fault_addr[1:0] != 2'b00));
  a_r4_far_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !align_abort |=> (align_abort || $stable(fault_addr)));
  a_r5_no_abort_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en |=> !align_abort);
endmodule

// File: tb/mem_access_dbg_chk_tb.sv
module mem_access_dbg_chk_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_store = 0, align_en = 0, bp_mask_mode = 0;
  logic [31:0] acc_addr = 0, dbg_csr = 0, bp_addr0 = 0, bp_addr1 = 0;
  logic [6:0] pid_field = 0;
  logic [1:0] bp_en0 = 0, bp_en1 = 0;
  logic [31:0] mapped_addr, fault_status, fault_addr, dbg_csr_upd;
  logic align_abort, bp_hit, moe_wr;

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_fsr = 0, e_far = 0, e_csr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_access_dbg_chk u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_map(input logic [31:0] a, input logic [6:0] p);
    if (p != 0 && a[31:25] == 0) return {p, a[24:0]};
    return a;
  endfunction

  function automatic logic f_kind(input logic [1:0] e, input logic st);
    case (e)
      2'd0: return 1'b0;
      2'd1: return st;
      2'd2: return 1'b1;
      default: return !st;
    endcase
  endfunction

  function automatic logic f_match(input logic [31:0] m);
    if (bp_mask_mode)
      return f_kind(bp_en0, acc_store) && ((m & ~bp_addr1) == (bp_addr0 & ~bp_addr1));
    return (f_kind(bp_en0, acc_store) && (m >> 2) == (bp_addr0 >> 2)) ||
           (f_kind(bp_en1, acc_store) && (m >> 2) == (bp_addr1 >> 2));
  endfunction

  task automatic access(input logic [31:0] a, input logic st);
    logic [31:0] m;
    logic ab, mt;
    @(negedge clk);
    acc_addr = a; acc_store = st; acc_valid = 1;
    m  = f_map(a, pid_field);
    ab = align_en && m[1:0] != 0;
    mt = f_match(m);
    if (ab) begin e_fsr = 32'h1; e_far = m; end
    if (mt && dbg_csr[31]) e_csr = {dbg_csr[31:5], 3'b010, dbg_csr[1:0]};
    @(negedge clk);
    acc_valid = 0;
    check((pid_field != 0 && a[31:25] == 0) ? "R2 mapped" : "R3 mapped", mapped_addr, m);
    check(align_en ? "R4 abort" : "R5 abort", {31'b0, align_abort}, {31'b0, ab});
    check("R4 fault_status", fault_status, e_fsr);
    check("R4 fault_addr", fault_addr, e_far);
    check(bp_mask_mode ? "R7 hit" : "R8 R6 hit", {31'b0, bp_hit}, {31'b0, mt && !dbg_csr[31]});
    check("R9 moe_wr", {31'b0, moe_wr}, {31'b0, mt && dbg_csr[31]});
    check("R9 csr_upd", dbg_csr_upd, e_csr);
    @(negedge clk);
    check("R10 pulses drop", {29'b0, align_abort, bp_hit, moe_wr}, 32'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 2 + 2);
    check("R1 mapped", mapped_addr, 0);
    check("R1 pulses", {29'b0, align_abort, bp_hit, moe_wr}, 0);
    check("R1 fault", fault_status | fault_addr, 0);
    check("R1 csr_upd", dbg_csr_upd, 0);
    rst_n = 1;

    // directed: relocation (R2, R3)
    pid_field = 7'h15;
    access(32'h0000_1000, 0);
    access(32'h0200_1000, 0);
    pid_field = 0;
    access(32'h0000_1000, 0);
    // alignment (R4, R5)
    align_en = 1; access(32'h0000_2003, 1);
    access(32'h0000_2004, 1);
    align_en = 0; access(32'h0000_2001, 1);
    // enable encoding (R6), dual mode ignores low bits (R8)
    bp_addr0 = 32'h0000_3000; bp_addr1 = 32'h0000_4000;
    bp_en0 = 2'd1; access(32'h0000_3002, 1); access(32'h0000_3002, 0);
    bp_en0 = 2'd3; access(32'h0000_3000, 1); access(32'h0000_3000, 0);
    bp_en0 = 2'd0; bp_en1 = 2'd2; access(32'h0000_4001, 0); access(32'h0000_3000, 0);
    // mask mode (R7): comparator 1 unused
    bp_mask_mode = 1; bp_en0 = 2'd2; bp_addr1 = 32'h0000_00ff;
    access(32'h0000_30a7, 0); access(32'h0000_3100, 0);
    bp_en0 = 2'd0; access(32'h0000_30a7, 0);
    // owned (R9)
    bp_en0 = 2'd2; dbg_csr = 32'h8000_001f; access(32'h0000_3011, 1);
    dbg_csr = 0; bp_mask_mode = 0;

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      pid_field = ($urandom % 3 == 0) ? 7'($urandom) : 7'd0;
      align_en = 1'($urandom);
      bp_mask_mode = 1'($urandom);
      bp_en0 = 2'($urandom); bp_en1 = 2'($urandom);
      bp_addr0 = $urandom; bp_addr1 = bp_mask_mode ? ($urandom & 32'h0000_0fff) : $urandom;
      dbg_csr = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h7fff_ffff);
      case ($urandom % 4)
        0: a = bp_addr0 ^ ($urandom & 32'h3);
        1: a = bp_addr1 ^ ($urandom & 32'h3);
        2: a = $urandom & 32'h01ff_ffff;
        default: a = $urandom;
      endcase
      if (pid_field != 0 && ($urandom % 2 == 0)) begin
        a[31:25] = 0;
        bp_addr0[31:25] = pid_field;
      end
      access(a, 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule